// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Pending Tracker

This block records software interrupts that the cores of a small multi-core cluster raise on one another. Each core has its own send port. A send names an interrupt number and carries a bit mask of target cores, so one write can raise the same interrupt on several targets at once. The sender's identity is the index of the port the write arrived on.

For every target core, the block keeps one pending bit per interrupt number and per sender. It raises that target's `irq` line while any of its bits is set. The target claims work by pulsing its acknowledge strobe. The block then picks one pending entry, clears it, and registers a claim word that names both the interrupt number and the sender. A repeated send of an entry that is already pending does not add a second event. Software is expected to drain a shared buffer on each claim, so merged sends lose no work.

A mode input can turn off banking by sender. When it does, all senders share one pending bit per target and interrupt number.

Top module: `sgi_tracker`

## Requirements
- R1: While `rstN` is low at a clock edge, every pending bit is cleared. After reset all `irq` outputs are 0 and every claim word reads the idle code 1023 (0x3FF).
- R2: A send with `sendValid[s]` high sets one pending bit for every target whose bit is set in that port's mask. The target's `irq` is high in the cycle after the send edge. Each target's mask is the 4-bit group `sendTargets[s*4 +: 4]`, with bit d selecting core d.
- R3: A send of an entry that is already pending leaves it as a single event. After any number of such repeats, one claim drains the entry.
- R4: In banked mode (`bankedMode`=1), sends of the same interrupt number from two different senders to one target stay separate, and each is returned by its own claim.
- R5: The claim word is 13 bits wide. Bits [3:0] hold the interrupt number, bits [12:10] hold the sender core ID, and bits [9:4] are 0. It is registered at the edge where `ackReq[d]` is high.
- R6: When several entries are pending for one target, a claim returns the lowest interrupt number first. Among entries with that number, it returns the lowest sender ID first.
- R7: A claim made while the target has nothing pending returns 1023 and changes no pending bit of any core.
- R8: A claim clears the returned entry at the same edge. The target's `irq` falls in the following cycle if nothing else is pending.
- R9: If a send and a claim hit the same pending bit at the same edge, the bit remains set.
- R10: In non-banked mode (`bankedMode`=0), sends of one interrupt number from different senders merge into one pending entry, and its claim word carries sender ID 0. The mode may change only while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bankedMode | input | 1 | 1: pending banked by sender; 0: shared across senders |
| sendValid | input | 4 | Send strobe, one per sender core |
| sendIntId | input | 16 | Interrupt number, 4 bits per sender |
| sendTargets | input | 16 | Target mask, 4 bits per sender |
| ackReq | input | 4 | Claim strobe, one per target core |
| ackData | output | 52 | Registered claim word, 13 bits per target |
| irq | output | 4 | Interrupt waiting, one per target |

## Verification
A pending bit stuck at 1 makes `irq` stay high and produces an extra claim word after the expected entries are drained. A pending bit stuck at 0 shows one cycle after the send, as a low `irq` or an early idle code. A selection error shows in the first claim word once two entries compete. Because the claim word is registered, every such fault is visible at the ports one edge after the claim strobe.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ACK_W     = 13;
  localparam int ACK_INT_W = 4;
  localparam int ACK_SRC_W = 3;
  localparam logic [ACK_W-1:0] IDLE_CODE = 13'd1023;

  // Control-to-datapath strobe for one target core's claim register.
  typedef struct packed {
    logic             load;
    logic [ACK_W-1:0] word;
  } ackStrobe_t;

  function automatic logic [ACK_W-1:0] packClaim(logic [ACK_INT_W-1:0] intId,
                                                 logic [ACK_SRC_W-1:0] srcId);
    return {srcId, 6'b000000, intId};
  endfunction
endpackage

// File: rtl/sgi_control.sv
module sgi_control
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_INTS  = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  bankedMode,
  input  logic [NUM_CORES-1:0]                  sendValid,
  input  logic [NUM_CORES*$clog2(NUM_INTS)-1:0] sendIntId,
  input  logic [NUM_CORES*NUM_CORES-1:0]        sendTargets,
  input  logic [NUM_CORES-1:0]                  ackReq,
  input  logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] pending,
  output logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] setBits,
  output logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] clrBits,
  output ackStrobe_t [NUM_CORES-1:0]            ackStb
);
  localparam int IW    = $clog2(NUM_INTS);
  localparam int SLICE = NUM_INTS * NUM_CORES;

  // Send decode: one set strobe per (target, interrupt, sender slot).
  always_comb begin
    setBits = '0;
    for (int s = 0; s < NUM_CORES; s++) begin
      for (int d = 0; d < NUM_CORES; d++) begin
        if (sendValid[s] && sendTargets[s*NUM_CORES+d]) begin
          setBits[(d*NUM_INTS + int'(sendIntId[s*IW +: IW]))*NUM_CORES
                  + (bankedMode ? s : 0)] = 1'b1;
        end
      end
    end
  end

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_tgt
    logic [SLICE-1:0]     pendSlice;
    logic [SLICE-1:0]     clrSlice;
    logic                 found;
    logic [ACK_INT_W-1:0] selInt;
    logic [ACK_SRC_W-1:0] selSrc;

    assign pendSlice = pending[d*SLICE +: SLICE];

    // Lowest interrupt number first, then lowest sender.
    always_comb begin
      found  = 1'b0;
      selInt = '0;
      selSrc = '0;
      for (int i = 0; i < NUM_INTS; i++) begin
        for (int s = 0; s < NUM_CORES; s++) begin
          if (!found && pendSlice[i*NUM_CORES+s]) begin
            found  = 1'b1;
            selInt = ACK_INT_W'(i);
            selSrc = ACK_SRC_W'(s);
          end
        end
      end
    end

    always_comb begin
      clrSlice = '0;
      if (ackReq[d] && found)
        clrSlice[int'(selInt)*NUM_CORES + int'(selSrc)] = 1'b1;
    end

    assign clrBits[d*SLICE +: SLICE] = clrSlice;
    assign ackStb[d].load = ackReq[d];
    assign ackStb[d].word = found ? packClaim(selInt, selSrc) : IDLE_CODE;

    // R8: one claim clears at most one entry per target.
    p_single_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(clrSlice));
    // R7: a clear strobe only ever targets an entry that is pending.
    p_clear_only_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
      (clrSlice & ~pendSlice) == '0);
  end
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_INTS  = 16
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] setBits,
  input  logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] clrBits,
  input  ackStrobe_t [NUM_CORES-1:0]              ackStb,
  output logic [NUM_CORES*NUM_INTS*NUM_CORES-1:0] pending,
  output logic [NUM_CORES*ACK_W-1:0]              ackData,
  output logic [NUM_CORES-1:0]                    irq
);
  localparam int SLICE = NUM_INTS * NUM_CORES;

  // Set wins over clear so a send racing a claim is kept.
  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrBits) | setBits;
  end

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN)               ackData[d*ACK_W +: ACK_W] <= IDLE_CODE;
      else if (ackStb[d].load) ackData[d*ACK_W +: ACK_W] <= ackStb[d].word;
    end
    assign irq[d] = |pending[d*SLICE +: SLICE];
  end

  // R9: every set strobe is present in the state one edge later.
  p_set_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pending & $past(setBits)) == $past(setBits)));
  // R8: a clear without a competing set empties the entry.
  p_clear_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pending & $past(clrBits & ~setBits)) == '0));
endmodule

// File: rtl/sgi_tracker.sv
module sgi_tracker
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_INTS  = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  bankedMode,
  input  logic [NUM_CORES-1:0]                  sendValid,
  input  logic [NUM_CORES*$clog2(NUM_INTS)-1:0] sendIntId,
  input  logic [NUM_CORES*NUM_CORES-1:0]        sendTargets,
  input  logic [NUM_CORES-1:0]                  ackReq,
  output logic [NUM_CORES*ACK_W-1:0]            ackData,
  output logic [NUM_CORES-1:0]                  irq
);
  localparam int TOTAL = NUM_CORES * NUM_INTS * NUM_CORES;

  initial begin
    if (NUM_INTS > (1 << ACK_INT_W) || NUM_CORES > (1 << ACK_SRC_W))
      $error("sgi_tracker: parameters exceed claim word fields");
  end

  logic [TOTAL-1:0]           pending;
  logic [TOTAL-1:0]           setBits;
  logic [TOTAL-1:0]           clrBits;
  ackStrobe_t [NUM_CORES-1:0] ackStb;

  sgi_control #(.NUM_CORES(NUM_CORES), .NUM_INTS(NUM_INTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bankedMode(bankedMode),
    .sendValid(sendValid), .sendIntId(sendIntId), .sendTargets(sendTargets),
    .ackReq(ackReq), .pending(pending),
    .setBits(setBits), .clrBits(clrBits), .ackStb(ackStb)
  );

  sgi_datapath #(.NUM_CORES(NUM_CORES), .NUM_INTS(NUM_INTS)) u_dp (
    .clk(clk), .rstN(rstN), .setBits(setBits), .clrBits(clrBits),
    .ackStb(ackStb), .pending(pending), .ackData(ackData), .irq(irq)
  );

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_chk
    // R7: a claim with nothing pending yields the idle code.
    p_idle_claim_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ackReq[d] && !irq[d]) |=> (ackData[d*ACK_W +: ACK_W] == IDLE_CODE));
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_src
      // R2: a targeted send raises the target's irq next cycle.
      p_send_raises_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sendValid[s] && sendTargets[s*NUM_CORES+d]) |=> irq[d]);
    end
  end
endmodule

// File: tb/sgi_tracker_tb.sv
module sgi_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NI = 16;
  localparam logic [12:0] IDLE = 13'd1023;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bankedMode = 1'b1;
  logic [NC-1:0] sendValid = '0;
  logic [NC*4-1:0] sendIntId = '0;
  logic [NC*NC-1:0] sendTargets = '0;
  logic [NC-1:0] ackReq = '0;
  logic [NC*13-1:0] ackData;
  logic [NC-1:0] irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_tracker #(.NUM_CORES(NC), .NUM_INTS(NI)) u_dut (
    .clk(clk), .rstN(rstN), .bankedMode(bankedMode), .sendValid(sendValid),
    .sendIntId(sendIntId), .sendTargets(sendTargets), .ackReq(ackReq),
    .ackData(ackData), .irq(irq)
  );

  function automatic logic [12:0] word(int src, int intId);
    return {3'(src), 6'b0, 4'(intId)};
  endfunction

  task automatic check(string req, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doSend(int src, int intId, logic [3:0] mask);
    @(negedge clk);
    sendValid[src] = 1'b1;
    sendIntId[src*4 +: 4] = 4'(intId);
    sendTargets[src*4 +: 4] = mask;
    @(negedge clk);
    sendValid = '0;
    sendTargets = '0;
  endtask

  task automatic doAck(int dst, output logic [12:0] w);
    @(negedge clk);
    ackReq[dst] = 1'b1;
    @(negedge clk);
    ackReq = '0;
    w = ackData[dst*13 +: 13];
  endtask

  task automatic testReset();
    check("R1 irq after reset", 13'(irq), 13'd0);
    for (int d = 0; d < NC; d++) check("R1 claim word after reset", ackData[d*13 +: 13], IDLE);
  endtask

  task automatic testSingle();
    logic [12:0] w;
    doSend(1, 5, 4'b0100);
    check("R2 single target irq", 13'(irq), 13'b0100);
    doAck(2, w);
    check("R5 claim word format", w, word(1, 5));
    check("R8 irq falls after claim", 13'(irq), 13'd0);
  endtask

  task automatic testMerge();
    logic [12:0] w;
    for (int k = 0; k < 3; k++) doSend(0, 3, 4'b0010);
    doAck(1, w);
    check("R3 merged first claim", w, word(0, 3));
    doAck(1, w);
    check("R3 no second event", w, IDLE);
  endtask

  task automatic testTwoSources();
    logic [12:0] w;
    doSend(3, 7, 4'b0001);
    doSend(0, 7, 4'b0001);
    doAck(0, w);
    check("R4 first sender", w, word(0, 7));
    doAck(0, w);
    check("R4 second sender", w, word(3, 7));
    doAck(0, w);
    check("R4 drained", w, IDLE);
  endtask

  task automatic testOrder();
    logic [12:0] w;
    doSend(2, 9, 4'b1000);
    doSend(1, 9, 4'b1000);
    doSend(0, 12, 4'b1000);
    doSend(3, 4, 4'b1000);
    doAck(3, w); check("R6 order 1", w, word(3, 4));
    doAck(3, w); check("R6 order 2", w, word(1, 9));
    doAck(3, w); check("R6 order 3", w, word(2, 9));
    doAck(3, w); check("R6 order 4", w, word(0, 12));
    check("R8 irq low after drain", 13'(irq), 13'd0);
  endtask

  task automatic testMulticast();
    logic [12:0] w;
    doSend(2, 0, 4'b1011);
    check("R2 multicast irq", 13'(irq), 13'b1011);
    doAck(0, w); check("R2 multicast core0", w, word(2, 0));
    doAck(1, w); check("R2 multicast core1", w, word(2, 0));
    doAck(3, w); check("R2 multicast core3", w, word(2, 0));
    check("R8 multicast drained", 13'(irq), 13'd0);
  endtask

  task automatic testIdleClaim();
    logic [12:0] w;
    doSend(1, 2, 4'b0001);
    doAck(1, w);
    check("R7 idle claim code", w, IDLE);
    check("R7 other core untouched", 13'(irq), 13'b0001);
    doAck(0, w);
    check("R7 other entry intact", w, word(1, 2));
  endtask

  task automatic testConflict();
    logic [12:0] w;
    doSend(0, 6, 4'b0010);
    @(negedge clk);
    ackReq[1] = 1'b1;
    sendValid[0] = 1'b1;
    sendIntId[3:0] = 4'd6;
    sendTargets[3:0] = 4'b0010;
    @(negedge clk);
    ackReq = '0; sendValid = '0; sendTargets = '0;
    check("R9 claim during send", ackData[13 +: 13], word(0, 6));
    check("R9 bit kept", 13'(irq), 13'b0010);
    doAck(1, w); check("R9 re-claim", w, word(0, 6));
    doAck(1, w); check("R9 drained", w, IDLE);
  endtask

  task automatic testNonBanked();
    logic [12:0] w;
    bankedMode = 1'b0;
    doSend(1, 8, 4'b0001);
    doSend(2, 8, 4'b0001);
    doAck(0, w); check("R10 merged across senders", w, word(0, 8));
    doAck(0, w); check("R10 single entry", w, IDLE);
    bankedMode = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testMerge();
    testTwoSources();
    testOrder();
    testMulticast();
    testIdleClaim();
    testConflict();
    testNonBanked();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule